// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block keeps a chip's internal reset asserted after power comes up, until the supply and the clock can be trusted. It steps through a chain of delay stages. First comes a fixed power-on delay. Next comes an optional power-up delay, selected by a configuration bit. For crystal oscillator modes, an oscillator start-up stage follows that counts oscillator cycles. In PLL mode a final lock delay is added before reset is released. The power-on detector is analog and lies outside the block; here it arrives as a single digital level.

An external reset can be applied at any time. It parks the sequencer in an idle hold. When it is released, the chain starts again. If the power-up stages had already completed, the restart begins at the oscillator stage. Otherwise the whole power-up chain runs again. All pins are plain control and status levels; no data stream passes through the block, so it has no valid/ready handshake. All delays except the oscillator stage count cycles of the block clock, which serves as the reference tick. The oscillator stage advances only in cycles where `osc_en` is high.

Top module: `rst_seq_top`

## Requirements
- R1: While `pwr_good` is low, `phase` is 0 (idle) and `rst_out` is 1, at once and regardless of the clock.
- R2: Once `pwr_good` is high and `ext_rst_n` is high, `phase` goes from 0 to 1 (power-on delay) for POR_CYC cycles. Then, with `pwrt_en`=1, it shows 2 (power-up delay) for PWRT_CYC cycles.
- R3: With `pwrt_en`=0, phase 2 never appears; the power-on delay leads straight to the oscillator stage or to release.
- R4: In crystal modes (`osc_mode` 2 = crystal, 3 = crystal with PLL), `phase` is 3 (oscillator start-up) until OST_CYC cycles with `osc_en`=1 have passed. A cycle with `osc_en`=0 does not advance it.
- R5: In modes 0 (RC) and 1 (external clock), phase 3 is skipped and release follows the power-up stages directly.
- R6: In mode 3 only, `phase` shows 4 (PLL lock) for PLL_CYC cycles after the oscillator stage, before release.
- R7: `rst_out` is 0 exactly when `phase` is 5 (released).
- R8: `ext_rst_n` low at a clock edge makes `phase` 0 and `rst_out` 1 from that edge on. The first edge with `ext_rst_n` high then restarts at the oscillator stage (or releases, in modes 0/1) if the power-up stages had finished.
- R9: If the external reset arrives before the power-up stages finish, the restart begins with the power-on delay. A restart after they have finished never shows phase 2.
- R10: Once released, `phase` stays 5 as long as `ext_rst_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; counts the power-on, power-up and PLL delays |
| pwr_good | input | 1 | Digital power-on detect, active high; low acts as asynchronous reset |
| ext_rst_n | input | 1 | External reset, active low, sampled on `clk` |
| pwrt_en | input | 1 | Enables the power-up delay stage |
| osc_mode | input | 2 | 0 RC, 1 external clock, 2 crystal, 3 crystal with PLL |
| osc_en | input | 1 | High in cycles where one oscillator period has elapsed |
| rst_out | output | 1 | Internal reset, active high |
| phase | output | 3 | 0 idle, 1 power-on delay, 2 power-up delay, 3 oscillator start-up, 4 PLL lock, 5 released |

## Verification
A wrong stage register shows on `phase` in the cycle after the faulty edge. It also shows on `rst_out` whenever the error crosses the released state. A stage counter that is off by one moves the next phase change by one cycle, and a cycle-exact comparison catches that at the boundary. A lost "power-up pending" flag only shows on the first external-reset restart. It appears there as a missing or unexpected phase 1 or 2, so both early and late resets during the power-up stages are exercised.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_POR  = 3'd1,
    PH_PWRT = 3'd2,
    PH_OST  = 3'd3,
    PH_PLL  = 3'd4,
    PH_REL  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    OM_RC   = 2'd0,
    OM_EC   = 2'd1,
    OM_XTAL = 2'd2,
    OM_XPLL = 2'd3
  } osc_mode_e;

  // crystal modes need the oscillator start-up stage
  function automatic logic mode_needs_ost(input logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic logic mode_has_pll(input logic [1:0] mode);
    return mode == OM_XPLL;
  endfunction

endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [CW-1:0] limit,
  output logic          last
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      cnt <= '0;
    else if (clear)
      cnt <= '0;
    else if (step)
      cnt <= cnt + CW'(1);
  end

  assign last = step && (cnt == (limit - CW'(1)));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int POR_CYC  = 16,
  parameter int PWRT_CYC = 1024,
  parameter int OST_CYC  = 1024,
  parameter int PLL_CYC  = 512,
  parameter int CW       = 11
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          ext_rst_n,
  input  logic          pwrt_en,
  input  logic [1:0]    osc_mode,
  input  logic          osc_en,
  input  logic          tmr_last,
  output logic          tmr_clear,
  output logic          tmr_step,
  output logic [CW-1:0] tmr_limit,
  output phase_e        phase_q
);

  phase_e st, nxt, entry;
  logic   pend;

  // stage that follows the power-up stages or an external-reset restart
  always_comb begin
    entry = mode_needs_ost(osc_mode) ? PH_OST : PH_REL;
  end

  always_comb begin
    nxt = st;
    unique case (st)
      PH_IDLE: nxt = pend ? PH_POR : entry;
      PH_POR:  if (tmr_last) nxt = pwrt_en ? PH_PWRT : entry;
      PH_PWRT: if (tmr_last) nxt = entry;
      PH_OST:  if (tmr_last) nxt = mode_has_pll(osc_mode) ? PH_PLL : PH_REL;
      PH_PLL:  if (tmr_last) nxt = PH_REL;
      PH_REL:  nxt = PH_REL;
      default: nxt = PH_IDLE;
    endcase
    if (!ext_rst_n)
      nxt = PH_IDLE;
  end

  always_comb begin
    tmr_step  = 1'b0;
    tmr_limit = CW'(1);
    unique case (st)
      PH_POR:  begin tmr_step = 1'b1;   tmr_limit = CW'(POR_CYC);  end
      PH_PWRT: begin tmr_step = 1'b1;   tmr_limit = CW'(PWRT_CYC); end
      PH_OST:  begin tmr_step = osc_en; tmr_limit = CW'(OST_CYC);  end
      PH_PLL:  begin tmr_step = 1'b1;   tmr_limit = CW'(PLL_CYC);  end
      default: begin tmr_step = 1'b0;   tmr_limit = CW'(1);        end
    endcase
  end

  assign tmr_clear = (nxt != st);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      st <= PH_IDLE;
    else
      st <= nxt;
  end

  // power-up stages still owed; only power loss sets it again
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      pend <= 1'b1;
    else if ((st == PH_POR || st == PH_PWRT) && (nxt == PH_OST || nxt == PH_REL))
      pend <= 1'b0;
  end

  assign phase_q = st;

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int POR_CYC  = 16,
  parameter int PWRT_CYC = 1024,
  parameter int OST_CYC  = 1024,
  parameter int PLL_CYC  = 512
) (
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       ext_rst_n,
  input  logic       pwrt_en,
  input  logic [1:0] osc_mode,
  input  logic       osc_en,
  output logic       rst_out,
  output logic [2:0] phase
);

  localparam int MAX_A = (POR_CYC > PWRT_CYC) ? POR_CYC : PWRT_CYC;
  localparam int MAX_B = (OST_CYC > PLL_CYC) ? OST_CYC : PLL_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXC + 1);

  logic          tmr_clear, tmr_step, tmr_last;
  logic [CW-1:0] tmr_limit;
  phase_e        ph;

  rst_seq_ctrl #(
    .POR_CYC (POR_CYC),
    .PWRT_CYC(PWRT_CYC),
    .OST_CYC (OST_CYC),
    .PLL_CYC (PLL_CYC),
    .CW      (CW)
  ) u_ctrl (
    .clk      (clk),
    .arst_n   (pwr_good),
    .ext_rst_n(ext_rst_n),
    .pwrt_en  (pwrt_en),
    .osc_mode (osc_mode),
    .osc_en   (osc_en),
    .tmr_last (tmr_last),
    .tmr_clear(tmr_clear),
    .tmr_step (tmr_step),
    .tmr_limit(tmr_limit),
    .phase_q  (ph)
  );

  rst_seq_timer #(
    .CW(CW)
  ) u_tmr (
    .clk   (clk),
    .arst_n(pwr_good),
    .clear (tmr_clear),
    .step  (tmr_step),
    .limit (tmr_limit),
    .last  (tmr_last)
  );

  assign phase   = ph;
  assign rst_out = (ph != PH_REL);

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       pwr_good,
  input logic       ext_rst_n,
  input logic       pwrt_en,
  input logic [1:0] osc_mode,
  input logic       osc_en,
  input logic       rst_out,
  input logic [2:0] phase
);

  a_r1_idle_when_no_power: assert property (@(posedge clk)
    !pwr_good |-> (phase == 3'd0 && rst_out));

  a_r8_ext_forces_idle: assert property (@(posedge clk) disable iff (!pwr_good)
    !ext_rst_n |=> (phase == 3'd0 && rst_out));

  a_r3_no_pwrt_when_off: assert property (@(posedge clk) disable iff (!pwr_good)
    (phase != 3'd2 && !pwrt_en) |=> phase != 3'd2);

  a_r4_ost_waits_for_osc: assert property (@(posedge clk) disable iff (!pwr_good)
    (phase == 3'd3 && !osc_en) |=> (phase == 3'd3 || phase == 3'd0));

  a_r6_pll_only_in_pll_mode: assert property (@(posedge clk) disable iff (!pwr_good)
    phase == 3'd4 |-> osc_mode == 2'd3);

  a_r5_crystal_release_path: assert property (@(posedge clk) disable iff (!pwr_good)
    ($rose(phase == 3'd5) && osc_mode[1]) |-> ($past(phase) == 3'd3 || $past(phase) == 3'd4));

  a_r7_released_only_in_phase5: assert property (@(posedge clk) disable iff (!pwr_good)
    !rst_out |-> phase == 3'd5);

  a_r10_release_sticks: assert property (@(posedge clk) disable iff (!pwr_good)
    (phase == 3'd5 && ext_rst_n) |=> (phase == 3'd5 && !rst_out));

endmodule

bind rst_seq_top rst_seq_chk u_chk (
  .clk      (clk),
  .pwr_good (pwr_good),
  .ext_rst_n(ext_rst_n),
  .pwrt_en  (pwrt_en),
  .osc_mode (osc_mode),
  .osc_en   (osc_en),
  .rst_out  (rst_out),
  .phase    (phase)
);

// File: tb/rst_seq_top_test.sv
`timescale 1ns/1ps
module rst_seq_top_test;

  localparam int POR_N  = 4;
  localparam int PWRT_N = 6;
  localparam int OST_N  = 5;
  localparam int PLL_N  = 3;

  logic       clk = 1'b0;
  logic       pwr_good = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       pwrt_en = 1'b1;
  logic [1:0] osc_mode = 2'd2;
  logic       osc_en = 1'b0;
  logic       osc_run = 1'b1;
  logic       rst_out;
  logic [2:0] phase;

  int checks = 0;
  int fails  = 0;
  bit [7:0] seen;

  always #5 clk = ~clk;

  rst_seq_top #(
    .POR_CYC(POR_N), .PWRT_CYC(PWRT_N), .OST_CYC(OST_N), .PLL_CYC(PLL_N)
  ) uut (
    .clk(clk), .pwr_good(pwr_good), .ext_rst_n(ext_rst_n), .pwrt_en(pwrt_en),
    .osc_mode(osc_mode), .osc_en(osc_en), .rst_out(rst_out), .phase(phase)
  );

  // behavioural reference: expected phase, remaining count, power-up owed
  int m_ph  = 0;
  int m_rem = 0;
  bit m_pend = 1'b1;

  task automatic m_enter_osc();
    if (osc_mode >= 2) begin m_ph = 3; m_rem = OST_N; end
    else m_ph = 5;
  endtask

  always @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      m_ph = 0; m_pend = 1'b1; m_rem = 0;
    end else if (!ext_rst_n) begin
      m_ph = 0;
    end else begin
      case (m_ph)
        0: if (m_pend) begin m_ph = 1; m_rem = POR_N; end else m_enter_osc();
        1: begin
             m_rem--;
             if (m_rem == 0) begin
               if (pwrt_en) begin m_ph = 2; m_rem = PWRT_N; end
               else begin m_pend = 1'b0; m_enter_osc(); end
             end
           end
        2: begin
             m_rem--;
             if (m_rem == 0) begin m_pend = 1'b0; m_enter_osc(); end
           end
        3: begin
             if (osc_en) m_rem--;
             if (m_rem == 0) begin
               if (osc_mode == 2'd3) begin m_ph = 4; m_rem = PLL_N; end
               else m_ph = 5;
             end
           end
        4: begin
             m_rem--;
             if (m_rem == 0) m_ph = 5;
           end
        default: m_ph = 5;
      endcase
    end
  end

  function automatic string tag_of(int p);
    case (p)
      0: return "R8";
      1: return "R2";
      2: return "R2";
      3: return "R4";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    seen[phase] = 1'b1;
    checks++;
    if (int'(phase) != m_ph) begin
      fails++;
      $display("FAIL %s phase: actual %0d expected %0d at %0t", tag_of(m_ph), phase, m_ph, $time);
    end
    checks++;
    if (rst_out != (m_ph != 5)) begin
      fails++;
      $display("FAIL R7 rst_out: actual %0d expected %0d at %0t", rst_out, (m_ph != 5), $time);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic power_up(input logic [1:0] mode, input logic en);
    cyc(1);
    pwr_good = 1'b0;
    #1;
    chk(phase == 3'd0 && rst_out, "R1 reset state", phase, 0);
    osc_mode = mode;
    pwrt_en  = en;
    cyc(3);
    chk(phase == 3'd0 && rst_out, "R1 held idle", phase, 0);
    pwr_good = 1'b1;
    seen = '0;
  endtask

  task automatic ext_pulse(input int n);
    ext_rst_n = 1'b0;
    cyc(n);
    ext_rst_n = 1'b1;
  endtask

  initial begin : osc_drv
    int k = 0;
    forever begin
      @(posedge clk);
      #2;
      k++;
      osc_en = osc_run && (k % 3 != 0);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // crystal, power-up delay on, oscillator stalled at first
    osc_run = 1'b0;
    power_up(2'd2, 1'b1);
    cyc(POR_N + PWRT_N + 6);
    chk(phase == 3'd3, "R4 stalled oscillator holds stage", phase, 3);
    osc_run = 1'b1;
    cyc(30);
    chk(phase == 3'd5 && !rst_out, "R7 released crystal", phase, 5);
    chk(seen[2] && seen[3] && !seen[4], "R2 stage path", int'(seen), 8'h2e);

    // external reset after release: restart at oscillator stage, no power-up delay
    seen = '0;
    ext_pulse(2);
    cyc(30);
    chk(!seen[2] && !seen[1] && seen[3], "R9 restart skips power-up stages", int'(seen), 8'h29);
    chk(phase == 3'd5, "R8 restart reaches release", phase, 5);
    cyc(10);
    chk(phase == 3'd5 && !rst_out, "R10 release stays", phase, 5);

    // PLL mode, external reset during the lock stage
    power_up(2'd3, 1'b1);
    cyc(40);
    chk(seen[4] && phase == 3'd5, "R6 lock stage then release", int'(seen), 8'h3e);
    ext_pulse(1);
    cyc(1);
    chk(phase == 3'd3, "R8 restart in oscillator stage", phase, 3);
    cyc(30);

    // external reset during power-up delay: whole chain reruns
    power_up(2'd2, 1'b1);
    cyc(1 + POR_N + 2);
    chk(phase == 3'd2, "R2 inside power-up delay", phase, 2);
    ext_pulse(3);
    seen = '0;
    cyc(40);
    chk(seen[1] && seen[2] && phase == 3'd5, "R9 early reset reruns power-up", int'(seen), 8'h2e);

    // external clock, power-up delay disabled
    power_up(2'd1, 1'b0);
    cyc(20);
    chk(!seen[2], "R3 power-up delay skipped", int'(seen), 8'h23);
    chk(!seen[3] && phase == 3'd5, "R5 no oscillator stage", int'(seen), 8'h23);

    // RC mode: restart after release goes straight back to release
    power_up(2'd0, 1'b1);
    cyc(20);
    seen = '0;
    ext_pulse(2);
    cyc(2);
    chk(phase == 3'd5 && !seen[3], "R5 RC restart releases at once", phase, 5);

    // power loss mid-sequence
    power_up(2'd3, 1'b1);
    cyc(5);
    pwr_good = 1'b0;
    #1;
    chk(phase == 3'd0 && rst_out, "R1 asynchronous drop", phase, 0);
    cyc(2);
    pwr_good = 1'b1;
    cyc(40);
    chk(phase == 3'd5, "R6 full PLL sequence after drop", phase, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule